// File: doc/BRIEF.md
# Reorder Buffer With In-Order Retirement

This block gives every instruction issued by an out-of-order core a slot in a circular queue, kept in program order. Each slot holds the instruction class (ALU, store or branch), its destination register, the produced value, an auxiliary word (store address or branch target), a completion flag, a misprediction flag and a fault flag. Execution units report finished work on a result broadcast that names the slot by its tag; the slot records it and becomes complete. Only the oldest slot may leave the queue, and only once complete: an ALU result is then written to the architectural register file, a store is sent to memory, and a mispredicted branch or a faulting instruction empties the whole machine.

The block also keeps a rename table mapping each architectural register to the slot that will produce it. Instructions being issued look up their source registers there and learn whether the value is pending, which slot produces it and, if that slot has already completed, the value itself, so that finished but unretired results are usable at once. Issue is accepted only when a slot is free and the external scheduler reports a free reservation station.

Top module: `inorder_retire_buf`

## Requirements
- R1: `iss_ready` is high only when fewer than 8 slots are occupied, `iss_rs_free` is high and no flush is signalled this cycle; an issue is taken only when `iss_valid` and `iss_ready` are both high.
- R2: Accepted issues receive tags 0,1,...,7,0,... in program order; `iss_tag` shows the tag the next accepted issue receives.
- R3: A broadcast (`cdb_valid`) naming an occupied slot stores value, auxiliary word, misprediction and fault flags and marks it complete; a broadcast naming a free slot has no effect.
- R4: At most one slot retires per cycle, always the oldest; `ret_valid` is high in every cycle where the oldest slot is complete and low while it is not, even when younger slots are complete.
- R5: An ALU-class slot (class code 0) without fault retires with `rf_we` high, `rf_waddr` equal to its destination and `rf_wdata` equal to its value, in the cycle after its completing broadcast if it is oldest.
- R6: A store-class slot (class code 1) without fault retires with `mem_we` high, `mem_addr` equal to its auxiliary word and `mem_wdata` equal to its value, and no register write.
- R7: A branch-class slot (class code 2) retiring with the misprediction flag raises `flush` and `redir_valid` with `redir_pc` equal to its auxiliary word; after that edge all slots are free, the rename table is empty and the next tag is 0. A correctly predicted branch retires with no other effect.
- R8: A slot retiring with its fault flag raises `excp_valid` and `flush`, writes neither registers nor memory, does not redirect, and empties the machine like R7.
- R9: For a mapped source register, `src_tag` gives the producing slot, `src_rdy` is high once that slot is complete, and `src_value` then carries its value.
- R10: `src_pend` is high for a register whose latest ALU writer has not retired; retiring an ALU slot clears the mapping only when it still names that slot, so a younger writer of the same register keeps it; an issue in the same cycle wins.
- R11: During a flush cycle `iss_ready` is low and any issue is ignored.
- R12: After reset the queue is empty: `iss_tag` is 0, no retire outputs are high and no source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_rs_free | input | 1 | A reservation station is free |
| iss_kind | input | 2 | Class: 0 ALU, 1 store, 2 branch |
| iss_dst | input | 5 | Destination register (ALU class) |
| iss_ready | output | 1 | Issue can be taken this cycle |
| iss_tag | output | 3 | Tag for the next accepted issue |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | 3 | Slot the result belongs to |
| cdb_value | input | 32 | Result value or store data |
| cdb_aux | input | 32 | Store address or branch target |
| cdb_mispred | input | 1 | Branch was mispredicted |
| cdb_excp | input | 1 | Instruction faulted |
| src_reg | input | 10 | Two source register numbers, port 0 in bits 4:0 |
| src_pend | output | 2 | Source is produced by an unretired slot |
| src_tag | output | 6 | Producing slot per port, 3 bits each |
| src_rdy | output | 2 | Producing slot is complete |
| src_value | output | 64 | Value of producing slot, 32 bits per port |
| ret_valid | output | 1 | Oldest slot retires this cycle |
| rf_we | output | 1 | Register file write |
| rf_waddr | output | 5 | Register written |
| rf_wdata | output | 32 | Data written |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Store address |
| mem_wdata | output | 32 | Store data |
| flush | output | 1 | Empty the machine |
| redir_valid | output | 1 | Restart fetch |
| redir_pc | output | 32 | Fetch restart address |
| excp_valid | output | 1 | Fault raised at retirement |

## Verification
A wrong pointer shows at `iss_tag` immediately and at the retire outputs as soon as the oldest slot completes, so a corrupted head or tail is visible within the cycle after the next broadcast. A stale or lost completion flag shows up either as a retire pulse for work never reported or as a queue that stops draining, and a lost mapping or a mapping that survived its producer shows on `src_pend`, `src_tag` and `src_rdy` in the very next cycle. A flush that leaves residue is exposed at the following issue, whose tag must be 0, and at any later lookup of a previously mapped register.

// File: rtl/irb_pkg.sv
// Shared types for the reorder buffer.
// Assumes: the class code is the two-bit value driven on the issue port.
package irb_pkg;
    typedef enum logic [1:0] {
        K_ALU    = 2'd0,
        K_STORE  = 2'd1,
        K_BRANCH = 2'd2
    } kind_e;
endpackage

// File: rtl/irb_ptrs.sv
// Head, tail and occupancy of the circular slot queue.
// Assumes: push is never raised when full and pop never when empty;
// clear returns everything to the reset state at the next edge.
module irb_ptrs #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clear,
    output logic [AW-1:0] head,
    output logic [AW-1:0] tail,
    output logic          full,
    output logic          empty
);
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Advance pointers and occupancy; clear or reset empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (pop)  head <= wrap_inc(head);
            if (push) tail <= wrap_inc(tail);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (empty && head == '0 && tail == '0));
endmodule

// File: rtl/irb_slots.sv
// Slot storage: class, destination, result, auxiliary word and flags.
// Allocation, result capture, retirement release and flush clear.
// Assumes: alloc targets a free slot; free targets a complete slot.
module irb_slots #(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int RW    = 5,
    parameter int NLOOK = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  alloc,
    input  logic [AW-1:0]         alloc_idx,
    input  logic [1:0]            alloc_kind,
    input  logic [RW-1:0]         alloc_dst,
    input  logic                  wb_valid,
    input  logic [AW-1:0]         wb_idx,
    input  logic [XLEN-1:0]       wb_value,
    input  logic [XLEN-1:0]       wb_aux,
    input  logic                  wb_mis,
    input  logic                  wb_exc,
    input  logic                  free,
    input  logic [AW-1:0]         hd_idx,
    output logic                  hd_busy,
    output logic                  hd_done,
    output logic [1:0]            hd_kind,
    output logic [RW-1:0]         hd_dst,
    output logic [XLEN-1:0]       hd_value,
    output logic [XLEN-1:0]       hd_aux,
    output logic                  hd_mis,
    output logic                  hd_exc,
    input  logic [NLOOK*AW-1:0]   lk_idx,
    output logic [NLOOK-1:0]      lk_done,
    output logic [NLOOK*XLEN-1:0] lk_value
);
    logic [DEPTH-1:0] busy, done, mis, exc;
    logic [1:0]       kind_q  [DEPTH];
    logic [RW-1:0]    dst_q   [DEPTH];
    logic [XLEN-1:0]  val_q   [DEPTH];
    logic [XLEN-1:0]  aux_q   [DEPTH];

    logic wb_hit;
    assign wb_hit = wb_valid && busy[wb_idx];

    // Control flags: capture, release, then allocation (allocation wins).
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            busy <= '0;
            done <= '0;
            mis  <= '0;
            exc  <= '0;
        end else begin
            if (wb_hit) begin
                done[wb_idx] <= 1'b1;
                mis[wb_idx]  <= wb_mis;
                exc[wb_idx]  <= wb_exc;
            end
            if (free) busy[hd_idx] <= 1'b0;
            if (alloc) begin
                busy[alloc_idx] <= 1'b1;
                done[alloc_idx] <= 1'b0;
                mis[alloc_idx]  <= 1'b0;
                exc[alloc_idx]  <= 1'b0;
            end
        end
    end

    // Payload storage, needs no reset since busy/done qualify it.
    always_ff @(posedge clk) begin
        if (wb_hit) begin
            val_q[wb_idx] <= wb_value;
            aux_q[wb_idx] <= wb_aux;
        end
        if (alloc) begin
            kind_q[alloc_idx] <= alloc_kind;
            dst_q[alloc_idx]  <= alloc_dst;
        end
    end

    assign hd_busy  = busy[hd_idx];
    assign hd_done  = done[hd_idx];
    assign hd_kind  = kind_q[hd_idx];
    assign hd_dst   = dst_q[hd_idx];
    assign hd_value = val_q[hd_idx];
    assign hd_aux   = aux_q[hd_idx];
    assign hd_mis   = mis[hd_idx];
    assign hd_exc   = exc[hd_idx];

    // One read port per source lookup.
    for (genvar g = 0; g < NLOOK; g++) begin : g_look
        logic [AW-1:0] idx;
        assign idx = lk_idx[g*AW +: AW];
        assign lk_done[g] = busy[idx] && done[idx];
        assign lk_value[g*XLEN +: XLEN] = val_q[idx];
    end

    a_r1_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !clear) |-> !busy[alloc_idx]);
    a_r4_free_complete: assert property (@(posedge clk) disable iff (!rst_n)
        free |-> (busy[hd_idx] && done[hd_idx]));
endmodule

// File: rtl/irb_rename.sv
// Rename table: per architectural register, the pending producer slot.
// Assumes: set and release are not raised in a clear cycle.
module irb_rename #(
    parameter int NREG  = 32,
    parameter int TW    = 3,
    parameter int NLOOK = 2,
    localparam int RW = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                set,
    input  logic [RW-1:0]       set_reg,
    input  logic [TW-1:0]       set_tag,
    input  logic                rel,
    input  logic [RW-1:0]       rel_reg,
    input  logic [TW-1:0]       rel_tag,
    input  logic [NLOOK*RW-1:0] lk_reg,
    output logic [NLOOK-1:0]    lk_pend,
    output logic [NLOOK*TW-1:0] lk_tag
);
    logic [NREG-1:0] map_v;
    logic [TW-1:0]   map_t [NREG];

    // Valid bits: conditional release, then a new mapping overrides.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            map_v <= '0;
        end else begin
            if (rel && map_v[rel_reg] && map_t[rel_reg] == rel_tag)
                map_v[rel_reg] <= 1'b0;
            if (set) map_v[set_reg] <= 1'b1;
        end
    end

    // Producer tags; qualified by the valid bits.
    always_ff @(posedge clk) begin
        if (set) map_t[set_reg] <= set_tag;
    end

    for (genvar g = 0; g < NLOOK; g++) begin : g_look
        logic [RW-1:0] r;
        assign r = lk_reg[g*RW +: RW];
        assign lk_pend[g] = map_v[r];
        assign lk_tag[g*TW +: TW] = map_t[r];
    end

    a_r10_issue_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clear) |=> map_v[$past(set_reg)]);
    a_r10_younger_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !set && !clear && map_v[rel_reg] && map_t[rel_reg] != rel_tag)
        |=> map_v[$past(rel_reg)]);
endmodule

// File: rtl/inorder_retire_buf.sv
// Reorder buffer top: issue handshake, result capture, in-order
// retirement to register file or memory, flush on mispredict or fault,
// and source operand lookup through the rename table.
// Assumes: DEPTH is at least 2; broadcasts name slots by issue tag.
module inorder_retire_buf
    import irb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int NLOOK = 2,
    localparam int TW = $clog2(DEPTH),
    localparam int RW = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_valid,
    input  logic                  iss_rs_free,
    input  logic [1:0]            iss_kind,
    input  logic [RW-1:0]         iss_dst,
    output logic                  iss_ready,
    output logic [TW-1:0]         iss_tag,
    input  logic                  cdb_valid,
    input  logic [TW-1:0]         cdb_tag,
    input  logic [XLEN-1:0]       cdb_value,
    input  logic [XLEN-1:0]       cdb_aux,
    input  logic                  cdb_mispred,
    input  logic                  cdb_excp,
    input  logic [NLOOK*RW-1:0]   src_reg,
    output logic [NLOOK-1:0]      src_pend,
    output logic [NLOOK*TW-1:0]   src_tag,
    output logic [NLOOK-1:0]      src_rdy,
    output logic [NLOOK*XLEN-1:0] src_value,
    output logic                  ret_valid,
    output logic                  rf_we,
    output logic [RW-1:0]         rf_waddr,
    output logic [XLEN-1:0]       rf_wdata,
    output logic                  mem_we,
    output logic [XLEN-1:0]       mem_addr,
    output logic [XLEN-1:0]       mem_wdata,
    output logic                  flush,
    output logic                  redir_valid,
    output logic [XLEN-1:0]       redir_pc,
    output logic                  excp_valid
);
    logic [TW-1:0]   head, tail;
    logic            full, empty;
    logic            hd_busy, hd_done, hd_mis, hd_exc;
    logic [1:0]      hd_kind;
    logic [RW-1:0]   hd_dst;
    logic [XLEN-1:0] hd_value, hd_aux;
    logic            accept;
    logic [NLOOK-1:0] lk_done;
    kind_e           hk;

    assign hk = kind_e'(hd_kind);

    // Retirement decode of the oldest slot.
    assign ret_valid   = hd_busy && hd_done;
    assign excp_valid  = ret_valid && hd_exc;
    assign redir_valid = ret_valid && !hd_exc && hk == K_BRANCH && hd_mis;
    assign redir_pc    = hd_aux;
    assign flush       = excp_valid || redir_valid;
    assign rf_we       = ret_valid && !hd_exc && hk == K_ALU;
    assign rf_waddr    = hd_dst;
    assign rf_wdata    = hd_value;
    assign mem_we      = ret_valid && !hd_exc && hk == K_STORE;
    assign mem_addr    = hd_aux;
    assign mem_wdata   = hd_value;

    // Issue handshake.
    assign iss_ready = !full && iss_rs_free && !flush;
    assign accept    = iss_valid && iss_ready;
    assign iss_tag   = tail;

    irb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .pop(ret_valid && !flush), .clear(flush),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    irb_slots #(.DEPTH(DEPTH), .XLEN(XLEN), .RW(RW), .NLOOK(NLOOK)) u_slots (
        .clk(clk), .rst_n(rst_n), .clear(flush),
        .alloc(accept), .alloc_idx(tail), .alloc_kind(iss_kind), .alloc_dst(iss_dst),
        .wb_valid(cdb_valid), .wb_idx(cdb_tag), .wb_value(cdb_value),
        .wb_aux(cdb_aux), .wb_mis(cdb_mispred), .wb_exc(cdb_excp),
        .free(ret_valid), .hd_idx(head),
        .hd_busy(hd_busy), .hd_done(hd_done), .hd_kind(hd_kind), .hd_dst(hd_dst),
        .hd_value(hd_value), .hd_aux(hd_aux), .hd_mis(hd_mis), .hd_exc(hd_exc),
        .lk_idx(src_tag), .lk_done(lk_done), .lk_value(src_value)
    );

    irb_rename #(.NREG(NREG), .TW(TW), .NLOOK(NLOOK)) u_rename (
        .clk(clk), .rst_n(rst_n), .clear(flush),
        .set(accept && kind_e'(iss_kind) == K_ALU), .set_reg(iss_dst), .set_tag(tail),
        .rel(rf_we), .rel_reg(hd_dst), .rel_tag(head),
        .lk_reg(src_reg), .lk_pend(src_pend), .lk_tag(src_tag)
    );

    assign src_rdy = src_pend & lk_done;

    a_r5_single_effect: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, mem_we, flush}));
    a_r7_flush_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (iss_tag == '0 && !ret_valid && src_pend == '0));
    a_r4_wait_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_valid && !empty && !(cdb_valid && cdb_tag == head)) |=> !ret_valid);
    a_r8_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        excp_valid |-> (!rf_we && !mem_we && !redir_valid));
endmodule

// File: tb/inorder_retire_buf_tb.sv
`timescale 1ns/1ps
module inorder_retire_buf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 0, iss_rs_free = 0;
    logic [1:0]  iss_kind = 0;
    logic [4:0]  iss_dst = 0;
    logic        iss_ready;
    logic [2:0]  iss_tag;
    logic        cdb_valid = 0;
    logic [2:0]  cdb_tag = 0;
    logic [31:0] cdb_value = 0, cdb_aux = 0;
    logic        cdb_mispred = 0, cdb_excp = 0;
    logic [9:0]  src_reg = 0;
    logic [1:0]  src_pend, src_rdy;
    logic [5:0]  src_tag;
    logic [63:0] src_value;
    logic        ret_valid, rf_we, mem_we, flush, redir_valid, excp_valid;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata, mem_addr, mem_wdata, redir_pc;

    always #2 clk = ~clk;

    inorder_retire_buf u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_rs_free(iss_rs_free),
        .iss_kind(iss_kind), .iss_dst(iss_dst), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value), .cdb_aux(cdb_aux),
        .cdb_mispred(cdb_mispred), .cdb_excp(cdb_excp), .src_reg(src_reg),
        .src_pend(src_pend), .src_tag(src_tag), .src_rdy(src_rdy), .src_value(src_value),
        .ret_valid(ret_valid), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .flush(flush),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .excp_valid(excp_valid)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // Reference model state
    bit          mb[8], md[8], mm[8], mx[8];
    logic [1:0]  mk[8];
    logic [4:0]  mdst[8];
    logic [31:0] mv[8], ma[8];
    int          mh, mt, mc;
    bit          mapv[32];
    int          mapt[32];
    bit          e_ret, e_flush, e_exc, e_mis, e_rf, e_mem, e_ready;

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 8; i++) begin mb[i] = 0; md[i] = 0; mm[i] = 0; mx[i] = 0; end
        for (int i = 0; i < 32; i++) mapv[i] = 0;
        mh = 0; mt = 0; mc = 0;
    endfunction

    // Compute expectations from model state and current inputs, compare.
    task automatic check_now();
        int h = mh;
        e_ret   = mb[h] && md[h];
        e_exc   = e_ret && mx[h];
        e_mis   = e_ret && !mx[h] && mk[h] == 2'd2 && mm[h];
        e_flush = e_exc || e_mis;
        e_rf    = e_ret && !mx[h] && mk[h] == 2'd0;
        e_mem   = e_ret && !mx[h] && mk[h] == 2'd1;
        e_ready = (mc < 8) && iss_rs_free && !e_flush;
        chk(e_flush ? "R11" : "R1", "iss_ready", iss_ready, e_ready);
        chk("R2", "iss_tag", iss_tag, mt);
        chk("R4", "ret_valid", ret_valid, e_ret);
        chk("R5", "rf_we", rf_we, e_rf);
        if (e_rf) begin
            chk("R5", "rf_waddr", rf_waddr, mdst[h]);
            chk("R5", "rf_wdata", rf_wdata, mv[h]);
        end
        chk("R6", "mem_we", mem_we, e_mem);
        if (e_mem) begin
            chk("R6", "mem_addr", mem_addr, ma[h]);
            chk("R6", "mem_wdata", mem_wdata, mv[h]);
        end
        chk("R7", "redir_valid", redir_valid, e_mis);
        if (e_mis) chk("R7", "redir_pc", redir_pc, ma[h]);
        chk("R8", "excp_valid", excp_valid, e_exc);
        chk(e_exc ? "R8" : "R7", "flush", flush, e_flush);
        for (int p = 0; p < 2; p++) begin
            int r = src_reg[p*5 +: 5];
            bit ep = mapv[r];
            bit er = ep && mb[mapt[r]] && md[mapt[r]];
            chk("R10", "src_pend", src_pend[p], ep);
            if (ep) chk("R9", "src_tag", src_tag[p*3 +: 3], mapt[r]);
            chk("R3", "src_rdy", src_rdy[p], er);
            if (er) chk("R9", "src_value", src_value[p*32 +: 32], mv[mapt[r]]);
        end
    endtask

    // Apply the edge to the model using the inputs held across it.
    function automatic void model_edge();
        bit acc = iss_valid && e_ready;
        if (e_flush) begin
            model_reset();
            return;
        end
        if (cdb_valid && mb[cdb_tag]) begin
            md[cdb_tag] = 1; mv[cdb_tag] = cdb_value; ma[cdb_tag] = cdb_aux;
            mm[cdb_tag] = cdb_mispred; mx[cdb_tag] = cdb_excp;
        end
        if (e_ret) begin
            if (e_rf && mapv[mdst[mh]] && mapt[mdst[mh]] == mh) mapv[mdst[mh]] = 0;
            mb[mh] = 0;
            mh = (mh + 1) % 8;
            mc--;
        end
        if (acc) begin
            mb[mt] = 1; md[mt] = 0; mm[mt] = 0; mx[mt] = 0;
            mk[mt] = iss_kind; mdst[mt] = iss_dst;
            if (iss_kind == 2'd0) begin mapv[iss_dst] = 1; mapt[iss_dst] = mt; end
            mt = (mt + 1) % 8;
            mc++;
        end
    endfunction

    task automatic cyc(input bit iv, input logic [1:0] k, input logic [4:0] d, input bit rs,
                       input bit bv, input logic [2:0] bt, input logic [31:0] bval,
                       input logic [31:0] baux, input bit bm, input bit be,
                       input logic [4:0] sa, input logic [4:0] sb);
        @(negedge clk);
        iss_valid = iv; iss_kind = k; iss_dst = d; iss_rs_free = rs;
        cdb_valid = bv; cdb_tag = bt; cdb_value = bval; cdb_aux = baux;
        cdb_mispred = bm; cdb_excp = be; src_reg = {sb, sa};
        #1;
        check_now();
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle(input logic [4:0] sa, input logic [4:0] sb);
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, sa, sb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R12: reset state
        iss_rs_free = 1; #1;
        chk("R12", "iss_tag after reset", iss_tag, 0);
        chk("R12", "ret_valid after reset", ret_valid, 0);
        chk("R12", "src_pend after reset", src_pend, 0);
        chk("R12", "iss_ready after reset", iss_ready, 1);

        // R3: broadcast to a free slot is ignored
        cyc(0, 0, 0, 1, 1, 3'd0, 32'hDEAD, 32'h0, 0, 0, 1, 2);
        // Fill all 8 slots with ALU writers of registers 1..8
        for (int i = 0; i < 8; i++) cyc(1, 2'd0, 5'(i + 1), 1, 0, 0, 0, 0, 0, 0, 1, 2);
        @(negedge clk); #1;
        chk("R1", "iss_ready when full", iss_ready, 0);
        chk("R3", "slot 0 not complete after idle broadcast", src_rdy[0], 0);
        cyc(1, 2'd0, 5'd9, 1, 0, 0, 0, 0, 0, 0, 1, 2);   // refused
        // Out of order completion: tags 2 and 1 before 0
        cyc(0, 0, 0, 1, 1, 3'd2, 32'h3333, 0, 0, 0, 3, 1);
        cyc(0, 0, 0, 1, 1, 3'd1, 32'h2222, 0, 0, 0, 3, 2);
        idle(3, 2);
        cyc(0, 0, 0, 1, 1, 3'd0, 32'h1111, 0, 0, 0, 1, 2);
        for (int i = 0; i < 4; i++) idle(1, 3);
        // Same register written twice, older retires first (R10)
        cyc(1, 2'd0, 5'd12, 1, 0, 0, 0, 0, 0, 0, 12, 4);
        cyc(1, 2'd0, 5'd12, 1, 0, 0, 0, 0, 0, 0, 12, 4);
        // Store and mispredicted branch in order behind pending work
        cyc(1, 2'd1, 5'd0, 1, 0, 0, 0, 0, 0, 0, 12, 4);
        for (int t = 3; t < 8; t++) cyc(0, 0, 0, 1, 1, 3'(t), 32'(t * 17), 32'(t * 5), 0, 0, 12, 4);
        for (int t = 0; t < 3; t++) cyc(0, 0, 0, 1, 1, 3'(t), 32'h55, 32'h1000, 0, 0, 12, 4);
        for (int i = 0; i < 10; i++) idle(12, 4);
        cyc(1, 2'd2, 5'd0, 1, 0, 0, 0, 0, 0, 0, 12, 4);
        cyc(1, 2'd0, 5'd6, 1, 0, 0, 0, 0, 0, 0, 6, 4);
        cyc(0, 0, 0, 1, 1, mt[2:0] - 3'd1, 32'h7, 32'h9, 0, 0, 6, 4);
        cyc(0, 0, 0, 1, 1, mt[2:0] - 3'd2, 32'h0, 32'hABC0, 1, 0, 6, 4);
        for (int i = 0; i < 3; i++) idle(6, 4);

        // Constrained random phase
        for (int n = 0; n < 6000; n++) begin
            bit iv = ($urandom % 100) < 60;
            int kr = $urandom % 10;
            logic [1:0] k = (kr < 6) ? 2'd0 : (kr < 8) ? 2'd1 : 2'd2;
            bit rs = ($urandom % 100) < 85;
            bit bv = 0;
            logic [2:0] bt = 3'($urandom % 8);
            int cand[$];
            for (int t = 0; t < 8; t++) if (mb[t] && !md[t]) cand.push_back(t);
            if (cand.size() > 0 && ($urandom % 100) < 70) begin
                bv = 1; bt = 3'(cand[$urandom % cand.size()]);
            end else if (($urandom % 100) < 10) bv = 1;
            cyc(iv, k, 5'($urandom % 8), rs, bv, bt, $urandom, $urandom,
                ($urandom % 100) < 20, ($urandom % 100) < 4,
                5'($urandom % 8), 5'($urandom % 8));
        end
        for (int i = 0; i < 20; i++) begin
            for (int t = 0; t < 8; t++)
                if (mb[t] && !md[t]) begin
                    cyc(0, 0, 0, 1, 1, 3'(t), 32'(t), 32'(t), 0, 0, 1, 2);
                    break;
                end
            idle(1, 2);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule